// File: doc/BRIEF.md
# Data-Processing Operand Shifter

This combinational unit forms the second operand of a data-processing instruction and the carry that the shift produces. It takes the 32-bit instruction word, the value of the register to be shifted, the low byte of the register that holds a shift amount, and the current carry flag. It returns the shifted or rotated operand and the shifter carry, which the ALU uses when a logical instruction updates its flags.

Three operand forms are decoded from the instruction word. The first is an 8-bit constant rotated right by an even amount. The second is a register shifted by a 5-bit constant. The third is a register shifted by an amount taken from another register. Shift amounts of zero, and register amounts of 32 or more, follow fixed encodings with their own carry rules. An index-mode input turns the unit into the offset shifter used for load/store addressing. In that mode only constant shift amounts exist, and the constant-operand select bit has no effect.

Top module: `operand_shifter`

## Requirements
- R1: When instr_word[25]=1 and index_mode=0, operand_out is instr_word[7:0], zero-extended, rotated right by 2*instr_word[11:8]. shift_carry equals carry_in when instr_word[11:8]=0 and equals operand_out[31] otherwise.
- R2: Shift-type field instr_word[6:5] encodes 00=LSL, 01=LSR, 10=ASR, 11=ROR. With instr_word[4]=0 the amount is instr_word[11:7]. A constant LSL by n in 1..31 gives rm_val<<n with carry rm_val[32-n]. A constant LSL by 0 gives rm_val with carry carry_in.
- R3: A constant LSR by n in 1..31 gives rm_val>>n with carry rm_val[n-1]. A constant LSR by 0 acts as a shift by 32: the result is 0 and the carry is rm_val[31].
- R4: A constant ASR by n in 1..31 shifts arithmetically with carry rm_val[n-1]. A constant ASR by 0 makes every result bit and the carry equal rm_val[31].
- R5: A constant ROR by n in 1..31 rotates right with carry rm_val[n-1]. A constant ROR by 0 gives {carry_in, rm_val[31:1]} with carry rm_val[0].
- R6: With instr_word[4]=1 and index_mode=0, the amount is rs_low and instr_word[7] is ignored. An amount of 0 returns rm_val with carry carry_in for every shift type.
- R7: A register LSL by 1..31 behaves as in R2. By exactly 32 it gives 0 with carry rm_val[0]. By more than 32 it gives 0 with carry 0.
- R8: A register LSR by 1..31 behaves as in R3. By exactly 32 it gives 0 with carry rm_val[31]. By more than 32 it gives 0 with carry 0.
- R9: A register ASR by 1..31 behaves as in R4. By 32 or more, every result bit and the carry equal rm_val[31].
- R10: A register ROR by a nonzero multiple of 32 returns rm_val with carry rm_val[31]. Any other nonzero amount rotates by the amount modulo 32 with carry rm_val[(amount mod 32)-1].
- R11: With index_mode=1, instr_word[25] and instr_word[4] are ignored. The operand is always rm_val shifted by the constant amount instr_word[11:7], with the rules of R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction word carrying the operand-form, shift-type and amount fields |
| rm_val | input | 32 | Value of the register being shifted |
| rs_low | input | 8 | Low byte of the register holding a shift amount |
| carry_in | input | 1 | Current carry flag |
| index_mode | input | 1 | 1 selects the load/store index variant |
| operand_out | output | 32 | Shifted, rotated or constant operand |
| shift_carry | output | 1 | Carry produced by the shifter |

## Verification
The hardest cases to reach are the register-amount boundaries. The carry changes rule at 0, at exactly 32, and above 32, and for ROR it depends on whether the amount is a multiple of 32. Random instruction words almost never hit these values, because the amount comes from a separate byte. The stimulus therefore steers rs_low through 0, 1, 31, 32, 33, 64 and 255 for each shift type. It pairs these with register values whose top and bottom bits differ, so a carry taken from the wrong end shows up. Index mode is exercised with instruction words that set both ignored select bits, which would send a design that honours them down the wrong path.

// File: rtl/opshift_pkg.sv
// Package: shared types for the operand shifter.
// Assumes a 32-bit datapath; the amount byte is 8 bits wide.
package opshift_pkg;

    // Shift kind, encoded as instruction bits 6:5
    typedef enum logic [1:0] {
        SHK_LSL = 2'd0,
        SHK_LSR = 2'd1,
        SHK_ASR = 2'd2,
        SHK_ROR = 2'd3
    } shk_e;

    localparam int AMT_W = 8;

    // Normalised shift request passed from the decoder to the barrel unit
    typedef struct packed {
        shk_e             kind;
        logic [AMT_W-1:0] amt;
        logic             rrx;
    } shreq_t;

endpackage

// File: rtl/opshift_ror.sv
// Module: logarithmic right rotator.
// Rotates din right by amt using one mux stage per amount bit.
// Assumes DATA_W is a power of two.
module opshift_ror #(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   amt,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] stage [SH_W+1];

    assign stage[0] = din;

    // One stage per amount bit: rotate by 2^k when that bit is set
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt[k]
            ? {stage[k][STEP-1:0], stage[k][DATA_W-1:STEP]}
            : stage[k];
    end

    assign dout = stage[SH_W];

endmodule

// File: rtl/opshift_decode.sv
// Module: operand-form decoder.
// Selects the rotated-constant form and turns the shift fields into a
// normalised request. Zero constant amounts map to their special meanings:
// LSR and ASR become 32, and ROR becomes rotate-through-carry.
// Assumes the standard 32-bit instruction field layout.
module opshift_decode
    import opshift_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [31:0]      instr_word,
    input  logic [AMT_W-1:0] rs_low,
    input  logic             index_mode,
    output shreq_t           req,
    output logic             sel_rot
);

    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    logic       reg_form;
    logic [4:0] imm_amt;
    shk_e       kind;

    // Decode the operand form; in index mode only constant shifts exist
    always_comb begin
        sel_rot  = instr_word[25] & ~index_mode;
        reg_form = instr_word[4]  & ~index_mode;
        kind     = shk_e'(instr_word[6:5]);
        imm_amt  = instr_word[11:7];
    end

    // Build the normalised request, resolving the zero constant encodings
    always_comb begin
        req.kind = kind;
        req.rrx  = 1'b0;
        req.amt  = '0;
        if (reg_form) begin
            req.amt = rs_low;
        end else if (imm_amt != 5'd0) begin
            req.amt = AMT_W'(imm_amt);
        end else begin
            unique case (kind)
                SHK_LSL: req.amt = '0;
                SHK_LSR: req.amt = FULL_AMT;
                SHK_ASR: req.amt = FULL_AMT;
                SHK_ROR: req.rrx = 1'b1;
                default: req.amt = '0;
            endcase
        end
    end

endmodule

// File: rtl/opshift_barrel.sv
// Module: shift/rotate core with carry-out.
// Executes a normalised request. Amount 0 passes the value through with the
// incoming carry. Amounts above DATA_W are clamped for ASR and zero the result
// for LSL and LSR. ROR uses the amount modulo DATA_W.
module opshift_barrel
    import opshift_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  shreq_t            req,
    input  logic [DATA_W-1:0] rm_val,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res,
    output logic              cout
);

    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W:0]            sh;
    logic                     over;
    logic [DATA_W:0]          lsl_ext;
    logic [DATA_W:0]          lsr_ext;
    logic signed [DATA_W:0]   asr_ext;
    logic [DATA_W-1:0]        ror_val;

    // Clamp the amount to DATA_W and flag amounts beyond it
    always_comb begin
        over = (req.amt > AMT_W'(DATA_W));
        sh   = over ? (SH_W+1)'(DATA_W) : req.amt[SH_W:0];
    end

    // Widened shifts: the extra bit catches the last bit shifted out
    always_comb begin
        lsl_ext = {1'b0, rm_val} << sh;
        lsr_ext = {rm_val, 1'b0} >> sh;
        asr_ext = $signed({rm_val, 1'b0}) >>> sh;
    end

    opshift_ror #(.DATA_W(DATA_W), .SH_W(SH_W)) u_ror (
        .din  (rm_val),
        .amt  (req.amt[SH_W-1:0]),
        .dout (ror_val)
    );

    // Select the result and carry for the requested kind and amount
    always_comb begin
        res  = rm_val;
        cout = carry_in;
        if (req.rrx) begin
            res  = {carry_in, rm_val[DATA_W-1:1]};
            cout = rm_val[0];
        end else if (req.amt != '0) begin
            unique case (req.kind)
                SHK_LSL: begin
                    res  = over ? '0   : lsl_ext[DATA_W-1:0];
                    cout = over ? 1'b0 : lsl_ext[DATA_W];
                end
                SHK_LSR: begin
                    res  = over ? '0   : lsr_ext[DATA_W:1];
                    cout = over ? 1'b0 : lsr_ext[0];
                end
                SHK_ASR: begin
                    res  = asr_ext[DATA_W:1];
                    cout = asr_ext[0];
                end
                SHK_ROR: begin
                    res  = ror_val;
                    cout = ror_val[DATA_W-1];
                end
                default: begin
                    res  = rm_val;
                    cout = carry_in;
                end
            endcase
        end
    end

endmodule

// File: rtl/opshift_rotimm.sv
// Module: rotated 8-bit constant.
// Rotates the zero-extended constant right by twice the 4-bit field.
// The carry is the incoming flag when the rotation is zero, else the result MSB.
module opshift_rotimm #(
    parameter int DATA_W = 32
) (
    input  logic [7:0]        imm8,
    input  logic [3:0]        rot4,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res,
    output logic              cout
);

    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] amt;

    // Double the rotate field to get the bit rotation
    always_comb amt = SH_W'({rot4, 1'b0});

    opshift_ror #(.DATA_W(DATA_W), .SH_W(SH_W)) u_ror (
        .din  (DATA_W'(imm8)),
        .amt  (amt),
        .dout (res)
    );

    // Carry rule for the constant form
    always_comb cout = (rot4 == 4'd0) ? carry_in : res[DATA_W-1];

endmodule

// File: rtl/operand_shifter.sv
// Module: data-processing operand shifter, top level.
// Purely combinational. Chooses between the rotated constant and the shifted
// register and returns the shifter carry. Assumes a 32-bit datapath and word.
module operand_shifter
    import opshift_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [31:0]       instr_word,
    input  logic [DATA_W-1:0] rm_val,
    input  logic [7:0]        rs_low,
    input  logic              carry_in,
    input  logic              index_mode,
    output logic [DATA_W-1:0] operand_out,
    output logic              shift_carry
);

    shreq_t            req;
    logic              sel_rot;
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;
    logic [DATA_W-1:0] ri_res;
    logic              ri_c;

    opshift_decode #(.DATA_W(DATA_W)) u_dec (
        .instr_word (instr_word),
        .rs_low     (rs_low),
        .index_mode (index_mode),
        .req        (req),
        .sel_rot    (sel_rot)
    );

    opshift_barrel #(.DATA_W(DATA_W)) u_bar (
        .req      (req),
        .rm_val   (rm_val),
        .carry_in (carry_in),
        .res      (sh_res),
        .cout     (sh_c)
    );

    opshift_rotimm #(.DATA_W(DATA_W)) u_rimm (
        .imm8     (instr_word[7:0]),
        .rot4     (instr_word[11:8]),
        .carry_in (carry_in),
        .res      (ri_res),
        .cout     (ri_c)
    );

    // Final operand select between the constant and the shifter
    always_comb begin
        operand_out = sel_rot ? ri_res : sh_res;
        shift_carry = sel_rot ? ri_c   : sh_c;
    end

endmodule

// File: rtl/operand_shifter_chk.sv
// Module: assertion checker for operand_shifter.
// The block has no clock, so the properties are immediate checks that relate
// the input fields to the outputs at the boundary encodings.
module operand_shifter_chk #(
    parameter int DATA_W = 32
) (
    input logic [31:0]       instr_word,
    input logic [DATA_W-1:0] rm_val,
    input logic [7:0]        rs_low,
    input logic              carry_in,
    input logic              index_mode,
    input logic [DATA_W-1:0] operand_out,
    input logic              shift_carry
);

    logic       rot_form;
    logic       cst_form;
    logic       reg_form;
    logic [1:0] kind;
    logic [4:0] cst_amt;

    // Classify the input as constant-rotate, constant-shift or register-shift
    always_comb begin
        rot_form = instr_word[25] & ~index_mode;
        cst_form = ~rot_form & (index_mode | ~instr_word[4]);
        reg_form = ~rot_form & ~cst_form;
        kind     = instr_word[6:5];
        cst_amt  = instr_word[11:7];
    end

    // Boundary relations between the fields and the outputs
    always_comb begin
        if (rot_form && instr_word[11:8] == 4'd0) begin
            a_r1_rot_zero: assert (operand_out == DATA_W'(instr_word[7:0]) && shift_carry == carry_in);
        end
        if (cst_form && cst_amt == 5'd0 && kind == 2'd1) begin
            a_r3_lsr_full: assert (operand_out == '0 && shift_carry == rm_val[DATA_W-1]);
        end
        if (cst_form && cst_amt == 5'd0 && kind == 2'd2) begin
            a_r4_asr_fill: assert (operand_out == {DATA_W{rm_val[DATA_W-1]}} && shift_carry == rm_val[DATA_W-1]);
        end
        if (cst_form && cst_amt == 5'd0 && kind == 2'd3) begin
            a_r5_rrx: assert (operand_out == {carry_in, rm_val[DATA_W-1:1]} && shift_carry == rm_val[0]);
        end
        if (reg_form && rs_low == 8'd0) begin
            a_r6_reg_zero: assert (operand_out == rm_val && shift_carry == carry_in);
        end
        if (reg_form && rs_low > 8'(DATA_W) && (kind == 2'd0 || kind == 2'd1)) begin
            a_r8_logic_over: assert (operand_out == '0 && !shift_carry);
        end
        if (reg_form && rs_low >= 8'(DATA_W) && kind == 2'd2) begin
            a_r9_asr_over: assert (operand_out == {DATA_W{rm_val[DATA_W-1]}} && shift_carry == rm_val[DATA_W-1]);
        end
    end

endmodule

bind operand_shifter operand_shifter_chk #(.DATA_W(DATA_W)) u_chk (
    .instr_word  (instr_word),
    .rm_val      (rm_val),
    .rs_low      (rs_low),
    .carry_in    (carry_in),
    .index_mode  (index_mode),
    .operand_out (operand_out),
    .shift_carry (shift_carry)
);

// File: tb/tb_operand_shifter.sv
// Directed bench for operand_shifter. Each scenario task drives inputs on the
// falling edge, samples 1 ns later, and compares with a bit-serial model.
module tb_operand_shifter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_word = '0;
    logic [31:0] rm_val = '0;
    logic [7:0]  rs_low = '0;
    logic        carry_in = 1'b0;
    logic        index_mode = 1'b0;
    logic [31:0] operand_out;
    logic        shift_carry;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    operand_shifter dut (
        .instr_word  (instr_word),
        .rm_val      (rm_val),
        .rs_low      (rs_low),
        .carry_in    (carry_in),
        .index_mode  (index_mode),
        .operand_out (operand_out),
        .shift_carry (shift_carry)
    );

    // Bit-serial model: shifts one place at a time, so the carry is the last bit out
    function automatic logic [32:0] model(input logic [31:0] ins, input logic [31:0] rm,
                                          input logic [7:0] rs, input logic c, input logic idx);
        logic [31:0] v;
        logic        cc;
        int          n;
        cc = c;
        if (ins[25] && !idx) begin
            v = {24'd0, ins[7:0]};
            n = 2 * int'(ins[11:8]);
            for (int i = 0; i < n; i++) v = {v[0], v[31:1]};
            if (n != 0) cc = v[31];
            return {cc, v};
        end
        v = rm;
        if (ins[4] && !idx) n = int'(rs);
        else begin
            n = int'(ins[11:7]);
            if (n == 0) begin
                if (ins[6:5] == 2'd1 || ins[6:5] == 2'd2) n = 32;
                if (ins[6:5] == 2'd3) return {rm[0], c, rm[31:1]};
            end
        end
        for (int i = 0; i < n; i++) begin
            case (ins[6:5])
                2'd0: begin cc = v[31]; v = {v[30:0], 1'b0}; end
                2'd1: begin cc = v[0];  v = {1'b0, v[31:1]}; end
                2'd2: begin cc = v[0];  v = {v[31], v[31:1]}; end
                default: begin cc = v[0]; v = {v[0], v[31:1]}; end
            endcase
        end
        return {cc, v};
    endfunction

    function automatic logic [31:0] mk_cst(input logic [1:0] k, input logic [4:0] a);
        return {20'd0, a, k, 1'b0, 4'd0};
    endfunction

    function automatic logic [31:0] mk_reg(input logic [1:0] k);
        return {20'h00000, 4'd3, 1'b1, k, 1'b1, 4'd0};
    endfunction

    function automatic logic [31:0] mk_rot(input logic [3:0] r, input logic [7:0] imm);
        return {6'd0, 1'b1, 13'd0, r, imm};
    endfunction

    task automatic drive(input logic [31:0] ins, input logic [31:0] rm,
                         input logic [7:0] rs, input logic c, input logic idx);
        @(negedge clk);
        instr_word = ins; rm_val = rm; rs_low = rs; carry_in = c; index_mode = idx;
        #1;
    endtask

    task automatic cmp(input string req, input logic [31:0] exp_v, input logic exp_c);
        n_checks++;
        if (operand_out !== exp_v || shift_carry !== exp_c) begin
            n_fail++;
            $display("FAIL %s: got %08h c=%0b, expected %08h c=%0b",
                     req, operand_out, shift_carry, exp_v, exp_c);
        end
    endtask

    task automatic run(input string req, input logic [31:0] ins, input logic [31:0] rm,
                       input logic [7:0] rs, input logic c, input logic idx);
        logic [32:0] e;
        drive(ins, rm, rs, c, idx);
        e = model(ins, rm, rs, c, idx);
        cmp(req, e[31:0], e[32]);
    endtask

    task automatic t_reset;
        drive('0, '0, '0, 1'b0, 1'b0);
        cmp("reset", 32'h0, 1'b0);
    endtask

    task automatic t_rotimm;  // R1
        drive(mk_rot(4'd4, 8'hFF), 32'h1234, 8'd0, 1'b0, 1'b0);
        cmp("R1", 32'hFF000000, 1'b1);
        drive(mk_rot(4'd0, 8'h5A), 32'hFFFF, 8'd0, 1'b1, 1'b0);
        cmp("R1", 32'h0000005A, 1'b1);
        drive(mk_rot(4'd1, 8'h01), 32'h0, 8'd0, 1'b1, 1'b0);
        cmp("R1", 32'h40000000, 1'b0);
        for (int r = 0; r < 16; r++) run("R1", mk_rot(4'(r), 8'hA5), 32'h0, 8'd0, 1'(r & 1), 1'b0);
    endtask

    task automatic t_cst_shifts;  // R2 R3 R4 R5
        drive(mk_cst(2'd0, 5'd0), 32'hDEADBEEF, 8'd0, 1'b1, 1'b0);
        cmp("R2", 32'hDEADBEEF, 1'b1);
        drive(mk_cst(2'd0, 5'd4), 32'hF0000001, 8'd0, 1'b0, 1'b0);
        cmp("R2", 32'h00000010, 1'b1);
        drive(mk_cst(2'd1, 5'd0), 32'h80000001, 8'd0, 1'b0, 1'b0);
        cmp("R3", 32'h0, 1'b1);
        drive(mk_cst(2'd2, 5'd0), 32'h80000000, 8'd0, 1'b0, 1'b0);
        cmp("R4", 32'hFFFFFFFF, 1'b1);
        drive(mk_cst(2'd3, 5'd0), 32'h00000003, 8'd0, 1'b1, 1'b0);
        cmp("R5", 32'h80000001, 1'b1);
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 32; a += 5) begin
                run(k == 0 ? "R2" : k == 1 ? "R3" : k == 2 ? "R4" : "R5",
                    mk_cst(2'(k), 5'(a)), 32'h9C3A_5E71, 8'hFF, 1'(a & 1), 1'b0);
            end
    endtask

    task automatic t_reg_shifts;  // R6 R7 R8 R9 R10
        for (int k = 0; k < 4; k++) begin
            drive(mk_reg(2'(k)) | 32'h80, 32'h8000_0001, 8'd0, 1'b1, 1'b0);
            cmp("R6", 32'h8000_0001, 1'b1);
        end
        drive(mk_reg(2'd0), 32'h1, 8'd32, 1'b0, 1'b0);  cmp("R7", 32'h0, 1'b1);
        drive(mk_reg(2'd0), 32'hFFFFFFFF, 8'd33, 1'b1, 1'b0); cmp("R7", 32'h0, 1'b0);
        drive(mk_reg(2'd1), 32'h80000000, 8'd32, 1'b0, 1'b0); cmp("R8", 32'h0, 1'b1);
        drive(mk_reg(2'd1), 32'hFFFFFFFF, 8'd40, 1'b1, 1'b0); cmp("R8", 32'h0, 1'b0);
        drive(mk_reg(2'd2), 32'h80000000, 8'd200, 1'b0, 1'b0); cmp("R9", 32'hFFFFFFFF, 1'b1);
        drive(mk_reg(2'd2), 32'h7FFFFFFF, 8'd32, 1'b1, 1'b0); cmp("R9", 32'h0, 1'b0);
        drive(mk_reg(2'd3), 32'h80000000, 8'd64, 1'b0, 1'b0); cmp("R10", 32'h80000000, 1'b1);
        drive(mk_reg(2'd3), 32'h00000010, 8'd36, 1'b1, 1'b0); cmp("R10", 32'h00000001, 1'b0);
        for (int k = 0; k < 4; k++) begin
            int amts[8] = '{1, 7, 31, 32, 33, 63, 64, 255};
            foreach (amts[i])
                run(k == 0 ? "R7" : k == 1 ? "R8" : k == 2 ? "R9" : "R10",
                    mk_reg(2'(k)), 32'hC000_0003, 8'(amts[i]), 1'(i & 1), 1'b0);
        end
    endtask

    task automatic t_index;  // R11
        // bit 25 and bit 4 set, amount field 4 (bit 7 = 0), LSR: plain constant shift
        drive(32'h0200_0230, 32'h0000_0F00, 8'd1, 1'b0, 1'b1);
        cmp("R11", 32'h0000_00F0, 1'b0);
        // ROR with zero amount in index mode is rotate-through-carry
        drive(32'h0200_0070, 32'h0000_0002, 8'd9, 1'b1, 1'b1);
        cmp("R11", 32'h8000_0001, 1'b0);
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 32; a += 9)
                run("R11", 32'h0200_0010 | mk_cst(2'(k), 5'(a)), 32'hA5A5_0F0F, 8'd3, 1'b1, 1'b1);
    endtask

    initial begin
        fork
            begin
                repeat (50000) @(posedge clk);
                if (!done) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL watchdog: got timeout, expected completion");
                    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
                    $finish;
                end
            end
        join_none
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rotimm();
        t_cst_shifts();
        t_reg_shifts();
        t_index();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule